// File: doc/BRIEF.md
# Slave Port Arbiter with Idle Parking

This block decides which of several bus masters owns a single slave port. Each master drives a request line and a burst-hold line. The arbiter returns a registered one-hot grant and a flag that is high whenever some master is connected. Configuration inputs select three things:

- the arbitration order, either rotating or strict priority;
- what the slave does when nobody requests it;
- a cycle budget after which a long burst may be interrupted by a waiting master.

When no master requests the slave, it can behave in one of three ways. It can drop every connection. It can stay attached to the master that used it last. It can attach to a chosen master index. When the slave is already attached to a master, that master's next request costs no arbitration cycle. A master that is not attached sees its grant one clock after raising its request. A master index that is out of range, or that names a master not wired to this slave, falls back to the disconnect behaviour.

The block is used beside the slave-side data multiplexer. Its grant selects the master path, and its connected flag qualifies the slave select.

Top module: `slave_port_arbiter`

## Requirements
- R1: The grant output has at most one bit set, and the connected flag is high exactly when a grant bit is set. During reset the grant is all zero.
- R2: With arbitration code 1, a re-arbitration gives the slave to the requesting master with the lowest index.
- R3: With arbitration code 0, a re-arbitration searches the masters starting at the one after the most recently granted master and wrapping around. Codes 2 and 3 behave as code 0.
- R4: While the granted master keeps both its request and its burst-hold line high, the grant does not change, unless R5 applies.
- R5: With a nonzero cycle budget L, an owner that holds a burst while another master requests keeps the grant for exactly L cycles. The grant then passes to a waiting master. The interrupted master keeps requesting and is granted again later by the normal order.
- R6: A cycle budget of 0 never interrupts a burst.
- R7: Parking code 0: when no master requests, the grant clears on the next clock. A master that then requests is granted one clock after its request.
- R8: Parking code 1: when no master requests, the grant stays on the last owner. When that owner requests again, it is granted in the same cycle, while any other master waits one clock.
- R9: Parking code 2: when no master requests, the grant moves on the next clock to the master whose index is on the parking-index input. When that master requests, it is granted in the same cycle.
- R10: Under parking code 2, an index of NUM_MASTERS or more, or an index whose bit in the CONNECTED_MASK parameter is 0, behaves as parking code 0. Parking code 3 also behaves as code 0.
- R11: A request with the burst-hold line low is a single access. The slave is re-arbitrated after every such cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_MASTERS | Per-master access request |
| burst_i | input | NUM_MASTERS | Per-master burst-hold, meaningful with the request |
| cfg_arb_mode | input | 2 | 0 rotating, 1 lowest-index priority, 2 and 3 rotating |
| cfg_park_mode | input | 2 | 0 disconnect, 1 last owner, 2 fixed index, 3 disconnect |
| cfg_park_idx | input | PARK_IDX_W | Master index parked under code 2 |
| cfg_slot_limit | input | SLOT_W | Burst cycle budget, 0 disables interruption |
| grant_o | output | NUM_MASTERS | One-hot grant, registered |
| connected_o | output | 1 | High when any master is granted |

## Verification
The case that is hardest to reach is the interruption of a burst. Two masters must hold bursts at the same time, and the test must then watch the grant alternate, with each owner keeping it for exactly the budgeted number of cycles. The stimulus first clears the slave, then raises both bursts together. It records the grant over nine consecutive clocks and compares the lengths of the runs against the budget. The same-cycle grant of a parked master is checked by sampling the grant in the cycle the request rises, before the next edge.

// File: rtl/slave_arb_pkg.sv
// Package: shared encodings for the slave port arbiter.
// Assumes 2-bit configuration codes; unlisted codes are mapped by the users.
package slave_arb_pkg;

    typedef enum logic [1:0] {
        ARB_ROTATE = 2'd0,
        ARB_PRIO   = 2'd1,
        ARB_RSV2   = 2'd2,
        ARB_RSV3   = 2'd3
    } arb_mode_e;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSV3  = 2'd3
    } park_mode_e;

endpackage

// File: rtl/arb_winner_pick.sv
// Module: arb_winner_pick
// Picks one master from a candidate vector, either the lowest index or the
// first one after last_idx in rotating order. Purely combinational.
// Assumes last_idx < N.
module arb_winner_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last_idx,
    input  logic          use_prio,
    output logic [N-1:0]  win
);

    int  pos;
    logic found;

    // Scan the candidates in the order the selected mode defines.
    always_comb begin
        win   = '0;
        found = 1'b0;
        pos   = 0;
        for (int k = 0; k < N; k++) begin
            if (use_prio) pos = k;
            else          pos = (int'(last_idx) + 1 + k) % N;
            if (!found && cand[pos]) begin
                win[pos] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/park_target.sv
// Module: park_target
// Computes the grant the slave should hold when no master is requesting.
// Assumes cur_grant is one-hot or zero; CONNECTED_MASK marks masters wired
// to this slave.
module park_target
    import slave_arb_pkg::*;
#(
    parameter int           N              = 4,
    parameter int           PARK_IDX_W     = 3,
    parameter logic [N-1:0] CONNECTED_MASK = '1
) (
    input  logic [1:0]            park_mode,
    input  logic [PARK_IDX_W-1:0] park_idx,
    input  logic [N-1:0]          cur_grant,
    output logic [N-1:0]          park_grant
);

    logic [N-1:0] fixed_hit;

    // One decode bit per master: index matches and the master is wired.
    for (genvar i = 0; i < N; i++) begin : g_hit
        assign fixed_hit[i] = (park_idx == PARK_IDX_W'(i)) && CONNECTED_MASK[i];
    end

    // Select the idle grant by parking policy; reserved code disconnects.
    always_comb begin
        unique case (park_mode)
            PARK_LAST:  park_grant = cur_grant;
            PARK_FIXED: park_grant = fixed_hit;
            default:    park_grant = '0;
        endcase
    end

endmodule

// File: rtl/slot_timer.sv
// Module: slot_timer
// Counts cycles the current owner has held the slave with its request up and
// flags when the budget is used. Restarts on any grant change or on an idle
// owner. Assumes limit 0 means no budget.
module slot_timer #(
    parameter int N      = 4,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      grant_q,
    input  logic [N-1:0]      grant_next,
    input  logic [N-1:0]      req,
    input  logic [SLOT_W-1:0] limit,
    output logic              expired
);

    localparam logic [SLOT_W-1:0] CNT_MAX = '1;

    logic [SLOT_W-1:0] cnt;
    logic              owner_req;

    assign owner_req = |(grant_q & req);

    // Budget reached when this is the limit-th held cycle.
    assign expired = (limit != '0) &&
                     ((SLOT_W+1)'(cnt) + (SLOT_W+1)'(1) >= (SLOT_W+1)'(limit));

    // Held-cycle counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt <= '0;
        else if (grant_next != grant_q || !owner_req) cnt <= '0;
        else if (cnt != CNT_MAX)                    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/slave_port_arbiter.sv
// Module: slave_port_arbiter (top)
// Registered one-hot grant of one slave among NUM_MASTERS masters, with
// rotating or priority order, idle parking and burst cycle budget.
// Assumes configuration inputs are quasi-static and req/burst are synchronous.
module slave_port_arbiter
    import slave_arb_pkg::*;
#(
    parameter int                     NUM_MASTERS    = 4,
    parameter int                     PARK_IDX_W     = 3,
    parameter int                     SLOT_W         = 8,
    parameter logic [NUM_MASTERS-1:0] CONNECTED_MASK = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] burst_i,
    input  logic [1:0]             cfg_arb_mode,
    input  logic [1:0]             cfg_park_mode,
    input  logic [PARK_IDX_W-1:0]  cfg_park_idx,
    input  logic [SLOT_W-1:0]      cfg_slot_limit,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic                   connected_o
);

    localparam int N  = NUM_MASTERS;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  grant_q, grant_next, cand, win, park_grant;
    logic [IW-1:0] last_idx, win_idx;
    logic          own_burst, others_req, expired, preempt, hold, rearb;

    assign own_burst  = |(grant_q & req_i & burst_i);
    assign others_req = |(req_i & ~grant_q);
    assign preempt    = own_burst && expired && others_req;
    assign hold       = own_burst && !preempt;
    assign cand       = preempt ? (req_i & ~grant_q) : req_i;
    assign rearb      = !hold && (cand != '0);

    arb_winner_pick #(.N(N), .IW(IW)) u_pick (
        .cand     (cand),
        .last_idx (last_idx),
        .use_prio (cfg_arb_mode == ARB_PRIO),
        .win      (win)
    );

    park_target #(.N(N), .PARK_IDX_W(PARK_IDX_W), .CONNECTED_MASK(CONNECTED_MASK)) u_park (
        .park_mode  (cfg_park_mode),
        .park_idx   (cfg_park_idx),
        .cur_grant  (grant_q),
        .park_grant (park_grant)
    );

    slot_timer #(.N(N), .SLOT_W(SLOT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_q    (grant_q),
        .grant_next (grant_next),
        .req        (req_i),
        .limit      (cfg_slot_limit),
        .expired    (expired)
    );

    // Encode the winner to an index for the rotation pointer.
    always_comb begin
        win_idx = '0;
        for (int k = 0; k < N; k++)
            if (win[k]) win_idx = IW'(k);
    end

    // Next grant: hold the burst, else arbitrate, else park.
    always_comb begin
        if (hold)       grant_next = grant_q;
        else if (rearb) grant_next = win;
        else            grant_next = park_grant;
    end

    // Grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= grant_next;
    end

    // Rotation pointer follows every arbitration win; reset points at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_idx <= IW'(N - 1);
        else if (rearb) last_idx <= win_idx;
    end

    assign grant_o     = grant_q;
    assign connected_o = |grant_q;

endmodule

// File: rtl/slave_port_arbiter_checker.sv
// Module: slave_port_arbiter_checker
// Temporal properties of the arbiter, observed at its ports. Bound below.
module slave_port_arbiter_checker #(
    parameter int NUM_MASTERS = 4,
    parameter int PARK_IDX_W  = 3,
    parameter int SLOT_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req_i,
    input logic [NUM_MASTERS-1:0] burst_i,
    input logic [1:0]             cfg_arb_mode,
    input logic [1:0]             cfg_park_mode,
    input logic [PARK_IDX_W-1:0]  cfg_park_idx,
    input logic [SLOT_W-1:0]      cfg_slot_limit,
    input logic [NUM_MASTERS-1:0] grant_o,
    input logic                   connected_o
);

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_arb_mode == 2'd1 && req_i != '0 && (grant_o & req_i & burst_i) == '0)
        |=> grant_o == ($past(req_i) & (~$past(req_i) + 1'b1)));

    p_burst_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_slot_limit == '0 && (grant_o & req_i & burst_i) != '0)
        |=> grant_o == $past(grant_o));

    p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd0 && req_i == '0) |=> grant_o == '0);

    p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd1 && req_i == '0) |=> grant_o == $past(grant_o));

    p_bad_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_mode == 2'd2 && req_i == '0 &&
         int'(cfg_park_idx) >= NUM_MASTERS) |=> grant_o == '0);

    p_grant_to_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((grant_o & ~$past(grant_o)) == '0) ||
                          ((grant_o & $past(req_i)) != '0));

endmodule

bind slave_port_arbiter slave_port_arbiter_checker #(
    .NUM_MASTERS (NUM_MASTERS),
    .PARK_IDX_W  (PARK_IDX_W),
    .SLOT_W      (SLOT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (req_i),
    .burst_i        (burst_i),
    .cfg_arb_mode   (cfg_arb_mode),
    .cfg_park_mode  (cfg_park_mode),
    .cfg_park_idx   (cfg_park_idx),
    .cfg_slot_limit (cfg_slot_limit),
    .grant_o        (grant_o),
    .connected_o    (connected_o)
);

// File: tb/slave_port_arbiter_test.sv
module slave_port_arbiter_test;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req, burst;
    logic [1:0] arb_mode, park_mode;
    logic [2:0] park_idx;
    logic [7:0] slot_limit;
    logic [3:0] grant;
    logic       connected;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slave_port_arbiter #(
        .NUM_MASTERS(N), .PARK_IDX_W(3), .SLOT_W(8), .CONNECTED_MASK(4'b1011)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .burst_i(burst),
        .cfg_arb_mode(arb_mode), .cfg_park_mode(park_mode),
        .cfg_park_idx(park_idx), .cfg_slot_limit(slot_limit),
        .grant_o(grant), .connected_o(connected)
    );

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_conn(string tag, logic exp);
        checks++;
        if (connected !== exp) begin
            failures++;
            $display("FAIL %s connected actual=%b expected=%b", tag, connected, exp);
        end
    endtask

    task automatic drive(logic [3:0] r, logic [3:0] b);
        @(negedge clk);
        req = r;
        burst = b;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = '0; burst = '0; arb_mode = 2'd0;
        park_mode = 2'd1; park_idx = 3'd0; slot_limit = '0;
        repeat (3) step();
        check("R1 reset", grant, 4'b0000);
        check_conn("R1 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_priority();
        arb_mode = 2'd1; park_mode = 2'd0;
        drive(4'b1010, 4'b0000); step();
        check("R2 lowest of 1010", grant, 4'b0010);
        check_conn("R1 connected", 1'b1);
        drive(4'b1100, 4'b0000); step();
        check("R2 lowest of 1100", grant, 4'b0100);
    endtask

    task automatic t_rotate();
        logic [3:0] g;
        arb_mode = 2'd0; park_mode = 2'd0;
        drive(4'b0000, 4'b0000); step();
        drive(4'b1111, 4'b0000); step();
        g = grant;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R3 R11 rotate", grant, {g[2:0], g[3]});
            g = grant;
        end
        arb_mode = 2'd2;
        for (int k = 0; k < 2; k++) begin
            step();
            check("R3 reserved code rotates", grant, {g[2:0], g[3]});
            g = grant;
        end
    endtask

    task automatic t_burst_hold();
        arb_mode = 2'd1; park_mode = 2'd0; slot_limit = '0;
        drive(4'b0000, 4'b0000); step();
        drive(4'b0001, 4'b0001); step();
        check("R4 burst start", grant, 4'b0001);
        drive(4'b0011, 4'b0001);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R4 R6 burst held", grant, 4'b0001);
        end
        drive(4'b0010, 4'b0000); step();
        check("R4 after burst end", grant, 4'b0010);
    endtask

    task automatic t_slot();
        logic [3:0] g [9];
        logic [3:0] x, y;
        arb_mode = 2'd0; park_mode = 2'd0; slot_limit = 8'd3;
        drive(4'b0000, 4'b0000); step();
        drive(4'b0011, 4'b0011);
        for (int k = 0; k < 9; k++) begin
            step();
            g[k] = grant;
        end
        x = g[0];
        y = x ^ 4'b0011;
        check("R5 first owner third cycle", g[2], x);
        check("R5 taken after budget", g[3], y);
        check("R5 second owner third cycle", g[5], y);
        check("R5 interrupted owner returns", g[6], x);
        slot_limit = '0;
    endtask

    task automatic t_park_none();
        arb_mode = 2'd1; park_mode = 2'd0;
        drive(4'b0000, 4'b0000); step();
        check("R7 idle disconnect", grant, 4'b0000);
        check_conn("R7 idle disconnect", 1'b0);
        drive(4'b0100, 4'b0000); #1;
        check("R7 no same-cycle grant", grant, 4'b0000);
        step();
        check("R7 grant one cycle later", grant, 4'b0100);
    endtask

    task automatic t_park_last();
        arb_mode = 2'd1; park_mode = 2'd1;
        drive(4'b0100, 4'b0000); step();
        drive(4'b0000, 4'b0000); step(); step();
        check("R8 stays on last owner", grant, 4'b0100);
        check_conn("R8 stays connected", 1'b1);
        drive(4'b0100, 4'b0000); #1;
        check("R8 same-cycle grant", grant, 4'b0100);
        drive(4'b0001, 4'b0000); #1;
        check("R8 other master waits", grant, 4'b0100);
        step();
        check("R8 other master next cycle", grant, 4'b0001);
    endtask

    task automatic t_park_fixed();
        arb_mode = 2'd1; park_mode = 2'd2; park_idx = 3'd3;
        drive(4'b0000, 4'b0000); step();
        check("R9 parks on index 3", grant, 4'b1000);
        drive(4'b1000, 4'b0000); #1;
        check("R9 same-cycle grant", grant, 4'b1000);
        step();
        check("R9 keeps parked master", grant, 4'b1000);
    endtask

    task automatic t_park_invalid();
        arb_mode = 2'd1; park_mode = 2'd2; park_idx = 3'd5;
        drive(4'b0100, 4'b0000); step();
        drive(4'b0000, 4'b0000); step();
        check("R10 index out of range", grant, 4'b0000);
        park_idx = 3'd2;
        drive(4'b0001, 4'b0000); step();
        drive(4'b0000, 4'b0000); step();
        check("R10 unwired master", grant, 4'b0000);
        park_mode = 2'd3;
        drive(4'b0010, 4'b0000); step();
        drive(4'b0000, 4'b0000); step();
        check("R10 reserved parking code", grant, 4'b0000);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_priority();
        t_rotate();
        t_burst_hold();
        t_slot();
        t_park_none();
        t_park_last();
        t_park_fixed();
        t_park_invalid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule